// File: doc/BRIEF.md
# Age-Filtered Squash Redirect Unit

This block sits between the back-end redirect sources (branch resolution, trap handling) and the front of the pipeline. Each cycle any of several sources may ask for a redirect of one thread. A request carries a sequence number, a target address and a mispredict flag. For each thread the unit keeps the sequence number of the youngest entry still live in the reorder buffer. A redirect counts only if it is strictly older than that value. An accepted redirect is broadcast to the earlier stages, and the youngest-live value then drops to the redirect's own sequence number. Any later request at that age or younger is stale and is dropped silently.

Once a redirect is accepted, the unit walks the reorder buffer back at a bounded rate. Each cycle it reports how many tail entries to remove. When the walk ends it raises a one-cycle completion pulse. While a thread is being walked back, that thread's allocation port reports not-ready. Sequence numbers wrap, so ages are compared modulo the counter width. Per-thread sequence numbers are assumed contiguous, which makes the number of entries to remove the distance between the youngest-live value and the redirect.

Top module: `sq_redirect_unit`

## Requirements
- R1: An accepted redirect appears on its thread's broadcast outputs one cycle after the request, as a one-cycle pulse carrying the request's sequence number, target and mispredict flag.
- R2: With no walk in progress and allocation ready, each accepted allocation makes its sequence number the thread's youngest-live value. A later redirect equal to or younger than it is dropped, and a strictly older one is accepted.
- R3: An accepted redirect replaces the youngest-live value with its own sequence number. A later redirect with the same or a younger sequence number produces no broadcast.
- R4: Sequence `a` is older than `b` when bit SEQ_W-1 of `(a - b) mod 2^SEQ_W` is 1, so ages compare correctly across counter wrap.
- R5: After acceptance, the entries to remove total `youngest - seq` (mod 2^SEQ_W). Each cycle with `kill_valid_o` high removes `kill_cnt_o = min(remaining, SQUASH_WIDTH)`. The first such cycle is the one right after the request.
- R6: `squash_done_o` is high for exactly one cycle, the cycle after the last cycle with `kill_valid_o` high.
- R7: At most one broadcast per thread per cycle. When several sources target the same thread in one cycle, the oldest sequence number wins and carries its own target and flag.
- R8: `alloc_ready_o` is low exactly while the thread's walk is in progress. An allocation offered while not ready leaves the youngest-live value unchanged.
- R9: A redirect older than the current youngest-live value is accepted even during a walk. It is broadcast and adds `previous youngest - seq` to the remaining count.
- R10: Threads are independent: a redirect or walk on one thread has no effect on another thread's outputs.
- R11: After reset, no broadcast, no removal and no completion pulse are active, and every thread is ready to allocate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | NUM_THREADS | Allocation offered per thread |
| alloc_seq_i | input | NUM_THREADS x SEQ_W | Sequence number of the allocated entry |
| alloc_ready_o | output | NUM_THREADS | Thread may allocate (no walk in progress) |
| redir_valid_i | input | NUM_SRC | Redirect request per source |
| redir_tid_i | input | NUM_SRC x TID_W | Thread of each request |
| redir_seq_i | input | NUM_SRC x SEQ_W | Squash-until sequence number |
| redir_target_i | input | NUM_SRC x ADDR_W | Redirect target address |
| redir_mispred_i | input | NUM_SRC | Request is a branch mispredict |
| bc_valid_o | output | NUM_THREADS | Squash broadcast pulse |
| bc_seq_o | output | NUM_THREADS x SEQ_W | Broadcast squash-until sequence number |
| bc_target_o | output | NUM_THREADS x ADDR_W | Broadcast target |
| bc_mispred_o | output | NUM_THREADS | Broadcast mispredict flag |
| kill_valid_o | output | NUM_THREADS | Entries removed this cycle |
| kill_cnt_o | output | NUM_THREADS x CNT_W | Number of entries removed this cycle |
| squash_done_o | output | NUM_THREADS | Walk finished pulse |

## Verification
Requests are applied just after a clock edge and take effect at the next edge. The broadcast and the first removal cycle are therefore due one cycle after the request, and completion is due one cycle after the last removal. The driver logs each expected broadcast in a per-thread queue, stamped with the edge at which it becomes due. The monitor checks outputs at the falling edge, so inputs and outputs are never compared at the active edge. There it pops and compares the due entry. It also advances a remaining-count model by min(remaining, SQUASH_WIDTH) per cycle and folds in the extra count of any accepted redirect at its due edge. Ready, removal count and completion are compared against that model in every cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // a older than b: sign bit of the modular difference
  function automatic logic seq_older(input logic [31:0] diff, input int unsigned w);
    return diff[w-1];
  endfunction

endpackage

// File: rtl/sq_pick.sv
module sq_pick
  import sq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned SEQ_W   = 8,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned TID_W   = 1,
  parameter int unsigned TID     = 0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SRC-1:0]                src_valid_i,
  input  logic [NUM_SRC-1:0][TID_W-1:0]     src_tid_i,
  input  logic [NUM_SRC-1:0][SEQ_W-1:0]     src_seq_i,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0]    src_target_i,
  input  logic [NUM_SRC-1:0]                src_mispred_i,
  output logic                              win_valid_o,
  output logic [SEQ_W-1:0]                  win_seq_o,
  output logic [ADDR_W-1:0]                 win_target_o,
  output logic                              win_mispred_o
);

  logic [NUM_SRC-1:0] hit;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++)
      hit[s] = src_valid_i[s] && (src_tid_i[s] == TID_W'(TID));
  end

  // linear scan, strictly older replaces: first source wins ties
  always_comb begin
    win_valid_o   = 1'b0;
    win_seq_o     = '0;
    win_target_o  = '0;
    win_mispred_o = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (hit[s] && (!win_valid_o ||
          seq_older(32'(src_seq_i[s] - win_seq_o), SEQ_W))) begin
        win_valid_o   = 1'b1;
        win_seq_o     = src_seq_i[s];
        win_target_o  = src_target_i[s];
        win_mispred_o = src_mispred_i[s];
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    p_oldest_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_valid_i[s] && src_tid_i[s] == TID_W'(TID)) |->
        (win_valid_o && !seq_older(32'(src_seq_i[s] - win_seq_o), SEQ_W)));
  end

endmodule

// File: rtl/sq_drain.sv
module sq_drain #(
  parameter int unsigned SEQ_W        = 8,
  parameter int unsigned SQUASH_WIDTH = 2,
  parameter int unsigned CNT_W        = $clog2(SQUASH_WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_valid_i,
  input  logic [SEQ_W-1:0] add_cnt_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] kill_cnt_o,
  output logic             done_o
);

  localparam logic [SEQ_W-1:0] STEP = SEQ_W'(SQUASH_WIDTH);

  logic [SEQ_W-1:0] rem_q, rem_n;
  logic             done_q;

  assign busy_o     = (rem_q != '0);
  assign kill_cnt_o = (rem_q >= STEP) ? CNT_W'(SQUASH_WIDTH) : CNT_W'(rem_q);
  assign done_o     = done_q;

  always_comb begin
    rem_n = rem_q - SEQ_W'(kill_cnt_o);
    if (add_valid_i) rem_n = rem_n + add_cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      done_q <= busy_o && (rem_n == '0);
    end
  end

  p_kill_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (kill_cnt_o != '0) && (kill_cnt_o <= CNT_W'(SQUASH_WIDTH)));

  p_partial_is_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && kill_cnt_o < CNT_W'(SQUASH_WIDTH) && !add_valid_i) |=> !busy_o);

  p_done_after_walk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: rtl/sq_thread.sv
module sq_thread
  import sq_pkg::*;
#(
  parameter int unsigned SEQ_W        = 8,
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SQUASH_WIDTH = 2,
  parameter int unsigned CNT_W        = $clog2(SQUASH_WIDTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [SEQ_W-1:0]  alloc_seq_i,
  output logic              alloc_ready_o,
  input  logic              win_valid_i,
  input  logic [SEQ_W-1:0]  win_seq_i,
  input  logic [ADDR_W-1:0] win_target_i,
  input  logic              win_mispred_i,
  output logic              bc_valid_o,
  output logic [SEQ_W-1:0]  bc_seq_o,
  output logic [ADDR_W-1:0] bc_target_o,
  output logic              bc_mispred_o,
  output logic              kill_valid_o,
  output logic [CNT_W-1:0]  kill_cnt_o,
  output logic              done_o
);

  logic [SEQ_W-1:0] youngest_q;
  logic [SEQ_W-1:0] youngest_pre;
  logic [SEQ_W-1:0] add_cnt;
  logic             accept;
  logic             alloc_fire;
  logic             busy;

  assign alloc_ready_o = !busy;
  assign alloc_fire    = alloc_valid_i && !busy;
  assign accept        = win_valid_i &&
                         seq_older(32'(win_seq_i - youngest_q), SEQ_W);
  // a same-cycle allocation is younger than any valid redirect: it is removed too
  assign youngest_pre  = alloc_fire ? alloc_seq_i : youngest_q;
  assign add_cnt       = youngest_pre - win_seq_i;
  assign kill_valid_o  = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      youngest_q   <= '0;
      bc_valid_o   <= 1'b0;
      bc_seq_o     <= '0;
      bc_target_o  <= '0;
      bc_mispred_o <= 1'b0;
    end else begin
      bc_valid_o <= accept;
      if (accept) begin
        youngest_q   <= win_seq_i;
        bc_seq_o     <= win_seq_i;
        bc_target_o  <= win_target_i;
        bc_mispred_o <= win_mispred_i;
      end else if (alloc_fire) begin
        youngest_q <= alloc_seq_i;
      end
    end
  end

  sq_drain #(
    .SEQ_W        (SEQ_W),
    .SQUASH_WIDTH (SQUASH_WIDTH),
    .CNT_W        (CNT_W)
  ) u_drain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .add_valid_i (accept),
    .add_cnt_i   (add_cnt),
    .busy_o      (busy),
    .kill_cnt_o  (kill_cnt_o),
    .done_o      (done_o)
  );

  p_bc_older_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_valid_o |-> seq_older(32'(bc_seq_o - $past(youngest_q)), SEQ_W));

  p_youngest_takes_bc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_valid_o |-> (youngest_q == bc_seq_o));

  p_alloc_tracks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_ready_o && !win_valid_i) |=> (youngest_q == $past(alloc_seq_i)));

  p_bc_starts_walk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_valid_o |-> kill_valid_o);

endmodule

// File: rtl/sq_redirect_unit.sv
module sq_redirect_unit #(
  parameter int unsigned NUM_THREADS  = 2,
  parameter int unsigned NUM_SRC      = 2,
  parameter int unsigned SEQ_W        = 8,
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SQUASH_WIDTH = 2,
  localparam int unsigned TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned CNT_W       = $clog2(SQUASH_WIDTH + 1)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_THREADS-1:0]              alloc_valid_i,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   alloc_seq_i,
  output logic [NUM_THREADS-1:0]              alloc_ready_o,
  input  logic [NUM_SRC-1:0]                  redir_valid_i,
  input  logic [NUM_SRC-1:0][TID_W-1:0]       redir_tid_i,
  input  logic [NUM_SRC-1:0][SEQ_W-1:0]       redir_seq_i,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0]      redir_target_i,
  input  logic [NUM_SRC-1:0]                  redir_mispred_i,
  output logic [NUM_THREADS-1:0]              bc_valid_o,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   bc_seq_o,
  output logic [NUM_THREADS-1:0][ADDR_W-1:0]  bc_target_o,
  output logic [NUM_THREADS-1:0]              bc_mispred_o,
  output logic [NUM_THREADS-1:0]              kill_valid_o,
  output logic [NUM_THREADS-1:0][CNT_W-1:0]   kill_cnt_o,
  output logic [NUM_THREADS-1:0]              squash_done_o
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic              win_valid;
    logic [SEQ_W-1:0]  win_seq;
    logic [ADDR_W-1:0] win_target;
    logic              win_mispred;

    sq_pick #(
      .NUM_SRC (NUM_SRC),
      .SEQ_W   (SEQ_W),
      .ADDR_W  (ADDR_W),
      .TID_W   (TID_W),
      .TID     (t)
    ) u_pick (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .src_valid_i   (redir_valid_i),
      .src_tid_i     (redir_tid_i),
      .src_seq_i     (redir_seq_i),
      .src_target_i  (redir_target_i),
      .src_mispred_i (redir_mispred_i),
      .win_valid_o   (win_valid),
      .win_seq_o     (win_seq),
      .win_target_o  (win_target),
      .win_mispred_o (win_mispred)
    );

    sq_thread #(
      .SEQ_W        (SEQ_W),
      .ADDR_W       (ADDR_W),
      .SQUASH_WIDTH (SQUASH_WIDTH),
      .CNT_W        (CNT_W)
    ) u_thread (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .alloc_valid_i (alloc_valid_i[t]),
      .alloc_seq_i   (alloc_seq_i[t]),
      .alloc_ready_o (alloc_ready_o[t]),
      .win_valid_i   (win_valid),
      .win_seq_i     (win_seq),
      .win_target_i  (win_target),
      .win_mispred_i (win_mispred),
      .bc_valid_o    (bc_valid_o[t]),
      .bc_seq_o      (bc_seq_o[t]),
      .bc_target_o   (bc_target_o[t]),
      .bc_mispred_o  (bc_mispred_o[t]),
      .kill_valid_o  (kill_valid_o[t]),
      .kill_cnt_o    (kill_cnt_o[t]),
      .done_o        (squash_done_o[t])
    );

    p_no_alloc_in_squash_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kill_valid_o[t] |-> !alloc_ready_o[t]);

    p_done_not_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      squash_done_o[t] |-> (alloc_ready_o[t] && !kill_valid_o[t]));
  end

endmodule

// File: tb/tb_sq_redirect_unit.sv
`timescale 1ns/1ps
module tb_sq_redirect_unit;
  localparam int NT = 2;
  localparam int NS = 2;
  localparam int SW = 8;
  localparam int AW = 16;
  localparam int W  = 2;
  localparam int CW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [NT-1:0]          alloc_valid;
  logic [NT-1:0][SW-1:0]  alloc_seq;
  logic [NT-1:0]          alloc_ready;
  logic [NS-1:0]          redir_valid;
  logic [NS-1:0][0:0]     redir_tid;
  logic [NS-1:0][SW-1:0]  redir_seq;
  logic [NS-1:0][AW-1:0]  redir_target;
  logic [NS-1:0]          redir_mispred;
  logic [NT-1:0]          bc_valid;
  logic [NT-1:0][SW-1:0]  bc_seq;
  logic [NT-1:0][AW-1:0]  bc_target;
  logic [NT-1:0]          bc_mispred;
  logic [NT-1:0]          kill_valid;
  logic [NT-1:0][CW-1:0]  kill_cnt;
  logic [NT-1:0]          done;

  sq_redirect_unit #(
    .NUM_THREADS(NT), .NUM_SRC(NS), .SEQ_W(SW), .ADDR_W(AW), .SQUASH_WIDTH(W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid), .alloc_seq_i(alloc_seq), .alloc_ready_o(alloc_ready),
    .redir_valid_i(redir_valid), .redir_tid_i(redir_tid), .redir_seq_i(redir_seq),
    .redir_target_i(redir_target), .redir_mispred_i(redir_mispred),
    .bc_valid_o(bc_valid), .bc_seq_o(bc_seq), .bc_target_o(bc_target),
    .bc_mispred_o(bc_mispred), .kill_valid_o(kill_valid), .kill_cnt_o(kill_cnt),
    .squash_done_o(done)
  );

  typedef struct {
    int          cyc;
    logic [SW-1:0] seq;
    logic [AW-1:0] tgt;
    logic        mp;
  } bc_item_t;

  bc_item_t      bc_q[NT][$];
  logic [SW-1:0] yng_m[NT];
  int            exp_rem[NT];
  int            pend_add[NT];
  int            pend_cyc[NT];
  bit            was_busy[NT];
  string         tag = "R11";
  int            cyc = 0;
  int            nchk = 0;
  int            nfail = 0;
  bit            mon_on = 1'b0;
  bit            finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit older(logic [SW-1:0] a, logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return d[SW-1];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // monitor: falling edge, outputs settled since the last rising edge
  always @(negedge clk) begin
    if (mon_on && !finished) begin
      for (int t = 0; t < NT; t++) begin
        int expk;
        expk = (exp_rem[t] > W) ? W : exp_rem[t];
        chk(alloc_ready[t] == (exp_rem[t] == 0), "R8", "alloc_ready", alloc_ready[t], exp_rem[t] == 0);
        chk(kill_valid[t] == (exp_rem[t] != 0), "R5", "kill_valid", kill_valid[t], exp_rem[t] != 0);
        if (exp_rem[t] != 0)
          chk(int'(kill_cnt[t]) == expk, "R5", "kill_cnt", kill_cnt[t], expk);
        chk(done[t] == (was_busy[t] && exp_rem[t] == 0), "R6", "squash_done", done[t],
            was_busy[t] && exp_rem[t] == 0);
        while (bc_q[t].size() > 0 && bc_q[t][0].cyc < cyc) begin
          chk(1'b0, tag, "missed broadcast", 0, 1);
          void'(bc_q[t].pop_front());
        end
        if (bc_q[t].size() > 0 && bc_q[t][0].cyc == cyc) begin
          bc_item_t it;
          it = bc_q[t].pop_front();
          chk(bc_valid[t] == 1'b1, tag, "bc_valid", bc_valid[t], 1);
          chk(bc_seq[t] == it.seq, tag, "bc_seq", bc_seq[t], it.seq);
          chk(bc_target[t] == it.tgt, tag, "bc_target", bc_target[t], it.tgt);
          chk(bc_mispred[t] == it.mp, tag, "bc_mispred", bc_mispred[t], it.mp);
        end else begin
          chk(bc_valid[t] == 1'b0, tag, "unexpected broadcast", bc_valid[t], 0);
        end
        was_busy[t] = (exp_rem[t] != 0);
        exp_rem[t]  = exp_rem[t] - expk;
        if (pend_cyc[t] == cyc + 1) exp_rem[t] = exp_rem[t] + pend_add[t];
      end
    end
  end

  task automatic clear_in();
    alloc_valid   = '0;
    alloc_seq     = '0;
    redir_valid   = '0;
    redir_tid     = '0;
    redir_seq     = '0;
    redir_target  = '0;
    redir_mispred = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    clear_in();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_alloc(int t, logic [SW-1:0] s);
    step();
    alloc_valid[t] = 1'b1;
    alloc_seq[t]   = s;
    if (exp_rem[t] == 0) yng_m[t] = s;
  endtask

  task automatic set_src(int i, int t, logic [SW-1:0] s, logic [AW-1:0] g, bit mp);
    redir_valid[i]   = 1'b1;
    redir_tid[i]     = 1'(t);
    redir_seq[i]     = s;
    redir_target[i]  = g;
    redir_mispred[i] = mp;
  endtask

  // driver side of the scoreboard: pick per thread, push expected broadcast
  task automatic predict();
    for (int t = 0; t < NT; t++) begin
      bit found;
      int wi;
      found = 1'b0;
      wi = 0;
      for (int i = 0; i < NS; i++)
        if (redir_valid[i] && int'(redir_tid[i]) == t)
          if (!found || older(redir_seq[i], redir_seq[wi])) begin
            found = 1'b1;
            wi = i;
          end
      if (found && older(redir_seq[wi], yng_m[t])) begin
        bc_item_t it;
        it.cyc = cyc + 1;
        it.seq = redir_seq[wi];
        it.tgt = redir_target[wi];
        it.mp  = redir_mispred[wi];
        bc_q[t].push_back(it);
        pend_add[t] = int'(SW'(yng_m[t] - redir_seq[wi]));
        pend_cyc[t] = cyc + 1;
        yng_m[t]    = redir_seq[wi];
      end
    end
  endtask

  task automatic do_redir(int t, logic [SW-1:0] s, logic [AW-1:0] g, bit mp);
    step();
    set_src(0, t, s, g, mp);
    predict();
  endtask

  task automatic do_two(int t0, logic [SW-1:0] s0, logic [AW-1:0] g0, bit m0,
                        int t1, logic [SW-1:0] s1, logic [AW-1:0] g1, bit m1);
    step();
    set_src(0, t0, s0, g0, m0);
    set_src(1, t1, s1, g1, m1);
    predict();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    clear_in();
    for (int t = 0; t < NT; t++) begin
      yng_m[t] = '0; exp_rem[t] = 0; pend_add[t] = 0; pend_cyc[t] = -1; was_busy[t] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    for (int t = 0; t < NT; t++) begin
      chk(bc_valid[t] == 1'b0, "R11", "bc_valid in reset", bc_valid[t], 0);
      chk(kill_valid[t] == 1'b0, "R11", "kill_valid in reset", kill_valid[t], 0);
      chk(done[t] == 1'b0, "R11", "done in reset", done[t], 0);
      chk(alloc_ready[t] == 1'b1, "R11", "alloc_ready in reset", alloc_ready[t], 1);
    end
    rst_ni = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R2: allocations move the youngest value
    tag = "R2";
    for (int s = 1; s <= 10; s++) do_alloc(0, SW'(s));
    do_alloc(1, 8'd20);
    do_redir(0, 8'd10, 16'h0bad, 1'b0);  // equal to youngest: dropped
    idle(2);
    tag = "R1";
    do_redir(0, 8'd6, 16'h1234, 1'b1);   // 4 entries, two cycles of removal
    tag = "R8";
    do_alloc(0, 8'd11);                  // blocked during the walk
    idle(4);
    tag = "R3";
    do_redir(0, 8'd6, 16'h2222, 1'b0);   // same age: stale
    do_redir(0, 8'd8, 16'h3333, 1'b0);   // younger: stale
    idle(1);
    tag = "R8";
    do_redir(0, 8'd5, 16'h4444, 1'b0);   // accepted, one entry: blocked alloc left no mark
    idle(3);

    // R9 and R10: older redirect during a walk, other thread in the same cycle
    tag = "R9";
    for (int s = 6; s <= 15; s++) do_alloc(0, SW'(s));
    do_redir(0, 8'd7, 16'h5555, 1'b1);   // 8 entries
    idle(1);
    tag = "R10";
    do_two(0, 8'd3, 16'h6666, 1'b0, 1, 8'd12, 16'h7777, 1'b1);
    idle(8);

    // R7: two sources hit one thread, oldest wins
    tag = "R7";
    do_two(0, 8'd2, 16'h8888, 1'b0, 0, 8'd1, 16'h9999, 1'b1);
    idle(3);
    do_two(0, 8'd0, 16'haaaa, 1'b1, 0, 8'd0, 16'hbbbb, 1'b0);  // tie: first source
    idle(3);

    // R4: ages across the counter wrap
    tag = "R4";
    for (int s = 250; s <= 260; s++) do_alloc(1, SW'(s));
    do_redir(1, 8'd253, 16'hcccc, 1'b0); // 7 entries: 254..4
    idle(1);
    do_redir(1, 8'd2, 16'hdddd, 1'b0);   // younger than 253: dropped
    idle(6);
    do_redir(1, 8'd252, 16'heeee, 1'b1); // older across nothing: one entry
    idle(4);

    for (int t = 0; t < NT; t++)
      chk(bc_q[t].size() == 0, "R1", "pending broadcasts left", bc_q[t].size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule